// File: doc/BRIEF.md
# Memory-Destination Arithmetic Micro-Op Cracker

This decode-stage block takes one simplified memory-destination arithmetic instruction per handshake and splits it into four internal micro-operations: a load of the old value, an arithmetic operation, a store-address operation and a store-data operation. The instruction is either an increment of the memory word or an add of an immediate to it. It carries a base register, an optional index register, an optional displacement and an immediate. Each micro-op leaves with the following fields:

- its type and the flags it writes;
- up to two sources, each either an architectural register or the tag of an earlier micro-op;
- its own destination tag;
- the index of the fused issue slot it shares with its neighbours.

The group also carries a count of the fused slots it occupies.

The arithmetic micro-op waits for the loaded data. The store-address micro-op depends only on the address registers, so it can run before or alongside the load. The store-data micro-op consumes the arithmetic result. The two opcode classes must produce different arithmetic micro-op types, because increment leaves carry untouched and add writes it. That difference also changes the fused grouping: add lets the load merge with the arithmetic operation, while increment does not. One output register holds the group under a valid/ready handshake until the consumer takes it.

Top module: `rmw_uop_cracker`

## Requirements
- R1: After reset, out_valid_o is 0 and in_ready_o is 1, and the first accepted instruction receives sequence number 0.
- R2: Every emitted group lists four micro-ops in the order load, arithmetic, store-address, store-data. Their type codes are load=0, increment-arith=1, add-arith=2, store-address=3, store-data=4, at uop positions 0, 1, 2 and 3.
- R3: When in_is_add_i=0, the arithmetic micro-op has type 1 and flag-write mask 2'b01 (bit 1 is carry, unchanged; bit 0 covers the other arithmetic flags). When in_is_add_i=1, it has type 2 and mask 2'b11. All other micro-ops have mask 2'b00.
- R4: The increment form gets fused slots 0,1,2,2 (uop 0..3) and a slot count of 3. The add form gets slots 0,0,1,1 and a slot count of 2.
- R5: The arithmetic micro-op has exactly one source, source 0. That source is a tag (is_tag=1) equal to the load's destination tag.
- R6: The load and store-address micro-ops take only registers as sources: source 0 is the base register, and source 1 is the index register only when in_has_idx_i=1. Neither takes a tag.
- R7: The store-data micro-op has exactly one source, source 0. That source is a tag equal to the arithmetic micro-op's destination tag.
- R8: The destination tag of uop i is {seq, i[1:0]}. seq advances by one, wrapping at 2^SEQ_W, for each accepted instruction.
- R9: The simple-addressing flag of all four micro-ops is 1 exactly when no index register is used.
- R10: While out_valid_o=1 and out_ready_i=0, all outputs hold stable and in_ready_o is 0.
- R11: out_imm_o is 1 for increment and in_imm_i for add. out_disp_o is in_disp_i when in_has_disp_i=1, and 0 otherwise.
- R12: With out_ready_i held at 1, one instruction is accepted per cycle, and its group appears on the outputs in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Instruction descriptor valid |
| in_ready_o | output | 1 | Descriptor accepted this cycle when valid |
| in_is_add_i | input | 1 | 0 = increment, 1 = add immediate |
| in_base_i | input | REG_W | Base register number |
| in_has_idx_i | input | 1 | Index register present |
| in_idx_i | input | REG_W | Index register number |
| in_has_disp_i | input | 1 | Displacement present |
| in_disp_i | input | DISP_W | Displacement |
| in_imm_i | input | IMM_W | Immediate for the add form |
| out_valid_o | output | 1 | Micro-op group valid |
| out_ready_i | input | 1 | Consumer takes the group |
| out_type_o | output | 4x3 | Micro-op type per position |
| out_flag_wr_o | output | 4x2 | Flag-write mask {carry, others} |
| out_src_vld_o | output | 4x2 | Source valid per micro-op |
| out_src_is_tag_o | output | 4x2 | Source is a micro-op tag (else register) |
| out_src_id_o | output | 4x2xID_W | Source register number or tag |
| out_dst_tag_o | output | 4xTAG_W | Destination tag |
| out_slot_o | output | 4x2 | Fused issue slot index |
| out_simple_am_o | output | 4 | Simple addressing mode flag |
| out_slot_cnt_o | output | 2 | Fused slots used by the group |
| out_disp_o | output | DISP_W | Effective displacement |
| out_imm_o | output | IMM_W | Arithmetic operand |

## Verification
Every cycle, the assertions check the structural shape of whatever group is valid:

- the position of each type;
- the agreement between the arithmetic type, its flag mask and the fused slots;
- that the arithmetic and store-data tag dependencies point at the right producers;
- that address micro-ops carry no tags;
- that tags sit in the right slot;
- that sequence numbers step across back-to-back handshakes;
- that the group holds while stalled.

Only the bench scenarios can show that the register numbers, displacement, immediate and index presence are the ones actually driven for each instruction. The same holds for the reset state, and for a stalled instruction being taken exactly once after the stall releases.

// File: rtl/rmw_cracker_pkg.sv
package rmw_cracker_pkg;

  localparam int NUOP = 4;

  typedef enum logic [2:0] {
    UOP_LOAD    = 3'd0,
    UOP_ALU_INC = 3'd1,
    UOP_ALU_ADD = 3'd2,
    UOP_STA     = 3'd3,
    UOP_STD     = 3'd4
  } uop_e;

  // flag-write mask: bit1 carry, bit0 remaining arithmetic flags
  localparam logic [1:0] FLG_NONE = 2'b00;
  localparam logic [1:0] FLG_NOCF = 2'b01;
  localparam logic [1:0] FLG_ALL  = 2'b11;

  localparam int POS_LD  = 0;
  localparam int POS_ALU = 1;
  localparam int POS_STA = 2;
  localparam int POS_STD = 3;

endpackage

// File: rtl/rmw_tag_alloc.sv
module rmw_tag_alloc #(
  parameter int SEQ_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [SEQ_W-1:0] seq_o
);

  logic [SEQ_W-1:0] seq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seq_q <= '0;
    else if (adv_i) seq_q <= seq_q + 1'b1;
  end

  assign seq_o = seq_q;

endmodule

// File: rtl/rmw_uop_gen.sv
module rmw_uop_gen
  import rmw_cracker_pkg::*;
#(
  parameter int REG_W  = 4,
  parameter int SEQ_W  = 3,
  parameter int DISP_W = 8,
  parameter int IMM_W  = 8,
  localparam int TAG_W = SEQ_W + 2,
  localparam int ID_W  = (REG_W > TAG_W) ? REG_W : TAG_W
) (
  input  logic                             is_add_i,
  input  logic [REG_W-1:0]                 base_i,
  input  logic                             has_idx_i,
  input  logic [REG_W-1:0]                 idx_i,
  input  logic                             has_disp_i,
  input  logic [DISP_W-1:0]                disp_i,
  input  logic [IMM_W-1:0]                 imm_i,
  input  logic [SEQ_W-1:0]                 seq_i,
  output logic [NUOP-1:0][2:0]             type_o,
  output logic [NUOP-1:0][1:0]             flag_wr_o,
  output logic [NUOP-1:0][1:0]             src_vld_o,
  output logic [NUOP-1:0][1:0]             src_is_tag_o,
  output logic [NUOP-1:0][1:0][ID_W-1:0]   src_id_o,
  output logic [NUOP-1:0][TAG_W-1:0]       dst_tag_o,
  output logic [NUOP-1:0][1:0]             slot_o,
  output logic [NUOP-1:0]                  simple_am_o,
  output logic [1:0]                       slot_cnt_o,
  output logic [DISP_W-1:0]                disp_o,
  output logic [IMM_W-1:0]                 imm_o
);

  for (genvar g = 0; g < NUOP; g++) begin : g_uop
    assign dst_tag_o[g]   = {seq_i, 2'(g)};
    assign simple_am_o[g] = ~has_idx_i;
  end

  logic [ID_W-1:0] base_id, idx_id;
  assign base_id = ID_W'(base_i);
  assign idx_id  = has_idx_i ? ID_W'(idx_i) : '0;

  always_comb begin
    type_o[POS_LD]  = UOP_LOAD;
    type_o[POS_ALU] = is_add_i ? UOP_ALU_ADD : UOP_ALU_INC;
    type_o[POS_STA] = UOP_STA;
    type_o[POS_STD] = UOP_STD;

    flag_wr_o          = '0;
    flag_wr_o[POS_ALU] = is_add_i ? FLG_ALL : FLG_NOCF;

    // address uops: registers only
    src_vld_o[POS_LD]    = {has_idx_i, 1'b1};
    src_is_tag_o[POS_LD] = 2'b00;
    src_id_o[POS_LD]     = {idx_id, base_id};
    src_vld_o[POS_STA]    = {has_idx_i, 1'b1};
    src_is_tag_o[POS_STA] = 2'b00;
    src_id_o[POS_STA]     = {idx_id, base_id};

    // data chain: load -> alu -> store-data
    src_vld_o[POS_ALU]    = 2'b01;
    src_is_tag_o[POS_ALU] = 2'b01;
    src_id_o[POS_ALU]     = {ID_W'(0), ID_W'(dst_tag_o[POS_LD])};
    src_vld_o[POS_STD]    = 2'b01;
    src_is_tag_o[POS_STD] = 2'b01;
    src_id_o[POS_STD]     = {ID_W'(0), ID_W'(dst_tag_o[POS_ALU])};

    if (is_add_i) begin
      slot_o     = {2'd1, 2'd1, 2'd0, 2'd0};
      slot_cnt_o = 2'd2;
    end else begin
      slot_o     = {2'd2, 2'd2, 2'd1, 2'd0};
      slot_cnt_o = 2'd3;
    end

    imm_o  = is_add_i ? imm_i : IMM_W'(1);
    disp_o = has_disp_i ? disp_i : '0;
  end

endmodule

// File: rtl/rmw_out_stage.sv
module rmw_out_stage #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  output logic         in_ready_o,
  input  logic [W-1:0] in_data_i,
  output logic         out_valid_o,
  input  logic         out_ready_i,
  output logic [W-1:0] out_data_o
);

  logic         vld_q;
  logic [W-1:0] dat_q;

  assign in_ready_o = ~vld_q | out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (in_ready_o) begin
      vld_q <= in_valid_i;
      if (in_valid_i) dat_q <= in_data_i;
    end
  end

  assign out_valid_o = vld_q;
  assign out_data_o  = dat_q;

endmodule

// File: rtl/rmw_uop_cracker.sv
module rmw_uop_cracker
  import rmw_cracker_pkg::*;
#(
  parameter int REG_W  = 4,
  parameter int SEQ_W  = 3,
  parameter int DISP_W = 8,
  parameter int IMM_W  = 8,
  localparam int TAG_W = SEQ_W + 2,
  localparam int ID_W  = (REG_W > TAG_W) ? REG_W : TAG_W
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           in_valid_i,
  output logic                           in_ready_o,
  input  logic                           in_is_add_i,
  input  logic [REG_W-1:0]               in_base_i,
  input  logic                           in_has_idx_i,
  input  logic [REG_W-1:0]               in_idx_i,
  input  logic                           in_has_disp_i,
  input  logic [DISP_W-1:0]              in_disp_i,
  input  logic [IMM_W-1:0]               in_imm_i,
  output logic                           out_valid_o,
  input  logic                           out_ready_i,
  output logic [3:0][2:0]                out_type_o,
  output logic [3:0][1:0]                out_flag_wr_o,
  output logic [3:0][1:0]                out_src_vld_o,
  output logic [3:0][1:0]                out_src_is_tag_o,
  output logic [3:0][1:0][ID_W-1:0]      out_src_id_o,
  output logic [3:0][TAG_W-1:0]          out_dst_tag_o,
  output logic [3:0][1:0]                out_slot_o,
  output logic [3:0]                     out_simple_am_o,
  output logic [1:0]                     out_slot_cnt_o,
  output logic [DISP_W-1:0]              out_disp_o,
  output logic [IMM_W-1:0]               out_imm_o
);

  typedef struct packed {
    logic [NUOP-1:0][2:0]           typ;
    logic [NUOP-1:0][1:0]           flg;
    logic [NUOP-1:0][1:0]           svld;
    logic [NUOP-1:0][1:0]           stag;
    logic [NUOP-1:0][1:0][ID_W-1:0] sid;
    logic [NUOP-1:0][TAG_W-1:0]     dst;
    logic [NUOP-1:0][1:0]           slot;
    logic [NUOP-1:0]                sam;
    logic [1:0]                     scnt;
    logic [DISP_W-1:0]              disp;
    logic [IMM_W-1:0]               imm;
  } grp_t;

  grp_t             grp_d, grp_q;
  logic [SEQ_W-1:0] seq;
  logic             accept;

  assign accept = in_valid_i & in_ready_o;

  rmw_tag_alloc #(.SEQ_W(SEQ_W)) u_tag (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (accept),
    .seq_o (seq)
  );

  rmw_uop_gen #(
    .REG_W (REG_W),
    .SEQ_W (SEQ_W),
    .DISP_W(DISP_W),
    .IMM_W (IMM_W)
  ) u_gen (
    .is_add_i    (in_is_add_i),
    .base_i      (in_base_i),
    .has_idx_i   (in_has_idx_i),
    .idx_i       (in_idx_i),
    .has_disp_i  (in_has_disp_i),
    .disp_i      (in_disp_i),
    .imm_i       (in_imm_i),
    .seq_i       (seq),
    .type_o      (grp_d.typ),
    .flag_wr_o   (grp_d.flg),
    .src_vld_o   (grp_d.svld),
    .src_is_tag_o(grp_d.stag),
    .src_id_o    (grp_d.sid),
    .dst_tag_o   (grp_d.dst),
    .slot_o      (grp_d.slot),
    .simple_am_o (grp_d.sam),
    .slot_cnt_o  (grp_d.scnt),
    .disp_o      (grp_d.disp),
    .imm_o       (grp_d.imm)
  );

  rmw_out_stage #(.W($bits(grp_t))) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .in_ready_o (in_ready_o),
    .in_data_i  (grp_d),
    .out_valid_o(out_valid_o),
    .out_ready_i(out_ready_i),
    .out_data_o (grp_q)
  );

  assign out_type_o       = grp_q.typ;
  assign out_flag_wr_o    = grp_q.flg;
  assign out_src_vld_o    = grp_q.svld;
  assign out_src_is_tag_o = grp_q.stag;
  assign out_src_id_o     = grp_q.sid;
  assign out_dst_tag_o    = grp_q.dst;
  assign out_slot_o       = grp_q.slot;
  assign out_simple_am_o  = grp_q.sam;
  assign out_slot_cnt_o   = grp_q.scnt;
  assign out_disp_o       = grp_q.disp;
  assign out_imm_o        = grp_q.imm;

endmodule

// File: rtl/rmw_uop_cracker_chk.sv
module rmw_uop_cracker_chk #(
  parameter int REG_W  = 4,
  parameter int SEQ_W  = 3,
  localparam int TAG_W = SEQ_W + 2,
  localparam int ID_W  = (REG_W > TAG_W) ? REG_W : TAG_W
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      in_valid_i,
  input logic                      in_ready_o,
  input logic                      out_valid_o,
  input logic                      out_ready_i,
  input logic [3:0][2:0]           out_type_o,
  input logic [3:0][1:0]           out_flag_wr_o,
  input logic [3:0][1:0]           out_src_vld_o,
  input logic [3:0][1:0]           out_src_is_tag_o,
  input logic [3:0][1:0][ID_W-1:0] out_src_id_o,
  input logic [3:0][TAG_W-1:0]     out_dst_tag_o,
  input logic [3:0][1:0]           out_slot_o,
  input logic [3:0]                out_simple_am_o,
  input logic [1:0]                out_slot_cnt_o
);

  p_order_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_type_o[0] == 3'd0 && out_type_o[2] == 3'd3 && out_type_o[3] == 3'd4 &&
                     (out_type_o[1] == 3'd1 || out_type_o[1] == 3'd2)));

  p_flags_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_flag_wr_o[1] == ((out_type_o[1] == 3'd2) ? 2'b11 : 2'b01) &&
                     out_flag_wr_o[0] == 2'b00 && out_flag_wr_o[2] == 2'b00 && out_flag_wr_o[3] == 2'b00));

  p_slots_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> ((out_type_o[1] == 3'd2) ?
                     (out_slot_cnt_o == 2'd2 && out_slot_o == {2'd1, 2'd1, 2'd0, 2'd0}) :
                     (out_slot_cnt_o == 2'd3 && out_slot_o == {2'd2, 2'd2, 2'd1, 2'd0})));

  p_alu_dep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_src_vld_o[1] == 2'b01 && out_src_is_tag_o[1][0] &&
                     out_src_id_o[1][0] == ID_W'(out_dst_tag_o[0])));

  p_addr_src_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_src_is_tag_o[0] == 2'b00 && out_src_is_tag_o[2] == 2'b00 &&
                     out_src_vld_o[0][0] && out_src_vld_o[2][0]));

  p_std_dep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_src_vld_o[3] == 2'b01 && out_src_is_tag_o[3][0] &&
                     out_src_id_o[3][0] == ID_W'(out_dst_tag_o[1])));

  p_tag_pos_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_dst_tag_o[0][1:0] == 2'd0 && out_dst_tag_o[1][1:0] == 2'd1 &&
                     out_dst_tag_o[2][1:0] == 2'd2 && out_dst_tag_o[3][1:0] == 2'd3 &&
                     out_dst_tag_o[3][TAG_W-1:2] == out_dst_tag_o[0][TAG_W-1:2]));

  p_seq_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && in_valid_i) |=>
      (out_dst_tag_o[0][TAG_W-1:2] == SEQ_W'($past(out_dst_tag_o[0][TAG_W-1:2]) + 1'b1)));

  p_am_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_simple_am_o == {4{~out_src_vld_o[0][1]}} &&
                     out_src_vld_o[2][1] == out_src_vld_o[0][1]));

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(out_type_o) && $stable(out_src_id_o) && $stable(out_dst_tag_o)));

  p_block_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |-> !in_ready_o);

endmodule

bind rmw_uop_cracker rmw_uop_cracker_chk #(.REG_W(REG_W), .SEQ_W(SEQ_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .in_valid_i      (in_valid_i),
  .in_ready_o      (in_ready_o),
  .out_valid_o     (out_valid_o),
  .out_ready_i     (out_ready_i),
  .out_type_o      (out_type_o),
  .out_flag_wr_o   (out_flag_wr_o),
  .out_src_vld_o   (out_src_vld_o),
  .out_src_is_tag_o(out_src_is_tag_o),
  .out_src_id_o    (out_src_id_o),
  .out_dst_tag_o   (out_dst_tag_o),
  .out_slot_o      (out_slot_o),
  .out_simple_am_o (out_simple_am_o),
  .out_slot_cnt_o  (out_slot_cnt_o)
);

// File: tb/rmw_uop_cracker_test.sv
`timescale 1ns/1ps
module rmw_uop_cracker_test;

  localparam int REG_W  = 4;
  localparam int SEQ_W  = 3;
  localparam int DISP_W = 8;
  localparam int IMM_W  = 8;
  localparam int TAG_W  = SEQ_W + 2;
  localparam int ID_W   = (REG_W > TAG_W) ? REG_W : TAG_W;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic                      in_valid, in_ready, in_is_add, in_has_idx, in_has_disp;
  logic [REG_W-1:0]          in_base, in_idx;
  logic [DISP_W-1:0]         in_disp;
  logic [IMM_W-1:0]          in_imm;
  logic                      out_valid, out_ready;
  logic [3:0][2:0]           o_type;
  logic [3:0][1:0]           o_flg, o_svld, o_stag, o_slot;
  logic [3:0][1:0][ID_W-1:0] o_sid;
  logic [3:0][TAG_W-1:0]     o_dst;
  logic [3:0]                o_sam;
  logic [1:0]                o_scnt;
  logic [DISP_W-1:0]         o_disp;
  logic [IMM_W-1:0]          o_imm;

  rmw_uop_cracker #(.REG_W(REG_W), .SEQ_W(SEQ_W), .DISP_W(DISP_W), .IMM_W(IMM_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_is_add_i(in_is_add),
    .in_base_i(in_base), .in_has_idx_i(in_has_idx), .in_idx_i(in_idx),
    .in_has_disp_i(in_has_disp), .in_disp_i(in_disp), .in_imm_i(in_imm),
    .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_type_o(o_type), .out_flag_wr_o(o_flg), .out_src_vld_o(o_svld),
    .out_src_is_tag_o(o_stag), .out_src_id_o(o_sid), .out_dst_tag_o(o_dst),
    .out_slot_o(o_slot), .out_simple_am_o(o_sam), .out_slot_cnt_o(o_scnt),
    .out_disp_o(o_disp), .out_imm_o(o_imm)
  );

  int n_run = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  typedef struct {
    logic add; logic [REG_W-1:0] base; logic hidx; logic [REG_W-1:0] idx;
    logic hdisp; logic [DISP_W-1:0] disp; logic [IMM_W-1:0] imm;
  } ins_t;

  task automatic drive(ins_t d);
    in_valid = 1'b1; in_is_add = d.add; in_base = d.base; in_has_idx = d.hidx;
    in_idx = d.idx; in_has_disp = d.hdisp; in_disp = d.disp; in_imm = d.imm;
  endtask

  task automatic check_grp(ins_t d, logic [SEQ_W-1:0] s);
    logic [TAG_W-1:0] t0, t1, t2, t3;
    logic [ID_W-1:0] b, x;
    t0 = {s, 2'd0}; t1 = {s, 2'd1}; t2 = {s, 2'd2}; t3 = {s, 2'd3};
    b = ID_W'(d.base); x = d.hidx ? ID_W'(d.idx) : '0;
    chk("R12", "out_valid", 64'(out_valid), 64'd1);
    chk("R2", "types", 64'(o_type), 64'({3'd4, 3'd3, (d.add ? 3'd2 : 3'd1), 3'd0}));
    chk("R3", "flag masks", 64'(o_flg), 64'({2'b00, 2'b00, (d.add ? 2'b11 : 2'b01), 2'b00}));
    chk("R4", "slots", 64'(o_slot), d.add ? 64'({2'd1, 2'd1, 2'd0, 2'd0}) : 64'({2'd2, 2'd2, 2'd1, 2'd0}));
    chk("R4", "slot count", 64'(o_scnt), d.add ? 64'd2 : 64'd3);
    chk("R5", "alu source", 64'({o_svld[1], o_stag[1], o_sid[1]}),
        64'({2'b01, 2'b01, ID_W'(0), ID_W'(t0)}));
    chk("R6", "load sources", 64'({o_svld[0], o_stag[0], o_sid[0]}), 64'({d.hidx, 1'b1, 2'b00, x, b}));
    chk("R6", "sta sources", 64'({o_svld[2], o_stag[2], o_sid[2]}), 64'({d.hidx, 1'b1, 2'b00, x, b}));
    chk("R7", "std source", 64'({o_svld[3], o_stag[3], o_sid[3]}),
        64'({2'b01, 2'b01, ID_W'(0), ID_W'(t1)}));
    chk("R8", "dest tags", 64'(o_dst), 64'({t3, t2, t1, t0}));
    chk("R9", "simple am", 64'(o_sam), 64'({4{~d.hidx}}));
    chk("R11", "imm", 64'(o_imm), d.add ? 64'(d.imm) : 64'd1);
    chk("R11", "disp", 64'(o_disp), d.hdisp ? 64'(d.disp) : 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    ins_t cur, prv, a, bb;
    logic [SEQ_W-1:0] seq_e, seq_p;
    in_valid = 0; in_is_add = 0; in_base = 0; in_has_idx = 0; in_idx = 0;
    in_has_disp = 0; in_disp = 0; in_imm = 0; out_ready = 1;
    seq_e = '0; seq_p = '0;
    prv = '{0, 0, 0, 0, 0, 0, 0};
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "out_valid in reset", 64'(out_valid), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1", "out_valid after reset", 64'(out_valid), 64'd0);
    chk("R1", "in_ready after reset", 64'(in_ready), 64'd1);

    // sweep, back-to-back (R12); first group checks seq 0 (R1)
    for (int k = 0; k < 128; k++) begin
      cur.base = 4'(k >> 3); cur.add = k[0]; cur.hidx = k[1]; cur.hdisp = k[2];
      cur.idx = 4'(15 - (k >> 3)); cur.disp = 8'(k * 7 + 3); cur.imm = 8'(k * 11 + 5);
      if (k > 0) check_grp(prv, seq_p);
      chk("R12", "in_ready streaming", 64'(in_ready), 64'd1);
      drive(cur);
      prv = cur; seq_p = seq_e; seq_e = seq_e + 1'b1;
      @(negedge clk);
    end
    check_grp(prv, seq_p);
    in_valid = 0;
    @(negedge clk);
    chk("R12", "out_valid after drain", 64'(out_valid), 64'd0);

    // backpressure (R10)
    a  = '{1'b0, 4'd9, 1'b1, 4'd2, 1'b1, 8'hA5, 8'h00};
    bb = '{1'b1, 4'd3, 1'b0, 4'd0, 1'b0, 8'h11, 8'h7E};
    out_ready = 0;
    drive(a);
    @(negedge clk);
    drive(bb);
    for (int i = 0; i < 3; i++) begin
      chk("R10", "in_ready while stalled", 64'(in_ready), 64'd0);
      check_grp(a, seq_e);
      @(negedge clk);
    end
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    check_grp(bb, seq_e + 1'b1);
    @(negedge clk);
    chk("R10", "single take after stall", 64'(out_valid), 64'd0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule